// File: doc/BRIEF.md
# Adaptive Multipath Egress Selector

This block picks which member link of an equal-cost group each outgoing packet uses. Every cycle it can take one packet descriptor: a valid strobe, the flow's 5-tuple (source and destination address, source and destination port, protocol) and the packet length in bytes. Two cycles later it returns the chosen member index with a valid flag. Packet parsing, queueing and the forwarding itself happen elsewhere.

Three selection modes are available. Static hashing pins each flow to one link. Flowlet steering starts a flow on its hashed link. When the flow's link has been carrying more than a threshold of bytes and the flow has paused for longer than an idle gap, the flow is moved to the least loaded link. Spraying gives each packet to the link with the fewest bytes sent so far in the current window, so consecutive packets of one flow spread across links. A small direct-mapped table holds per-flow state. Per-link byte meters run over a fixed window of cycles. Configuration inputs set the mode, the member enable mask, the byte threshold and the idle gap.

Top module: `multipath_egress_sel`

## Requirements
- R1: A descriptor with `inValid` high at rising edge k produces `outValid` high after edge k+1, provided at least one member is enabled at edge k+1. One descriptor is accepted per cycle with no stall. `outValid` is low in every other cycle.
- R2: The flow key is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, computed MSB first over the 104-bit value {srcAddr, dstAddr, srcPort, dstPort, protocol}. The hashed link is found by starting at index crc[15:8] mod NUM_LINKS and taking the first enabled member, counting upward and wrapping. In static mode (`cfgMode` = 0), every packet gets its hashed link, whatever the link's load.
- R3: In flowlet mode (`cfgMode` = 1), a packet whose table entry is not valid gets its hashed link. The table entry index is crc[7:0] mod TBL_DEPTH.
- R4: In flowlet mode, a packet whose entry is valid keeps the entry's link if that link is enabled and the timestamp gap since the entry was last written is no greater than `cfgIdleGap`. This holds even when the link is loaded past the threshold.
- R5: In flowlet mode, a packet whose entry is valid and whose gap exceeds `cfgIdleGap` starts a new flowlet. If the entry's link has a previous-window byte count greater than `cfgThreshold`, the packet moves to the enabled member with the smallest previous-window count, with ties going to the lowest index. Otherwise it stays on the entry's link.
- R6: In spray mode (`cfgMode` = 2), each packet gets the enabled member with the smallest current-window byte count, with ties going to the lowest index. The current-window count includes every packet already returned.
- R7: Each link's current-window count adds the length of every packet returned on it, saturating at all ones. A free-running cycle counter spans WIN_CYCLES cycles. At the last cycle of each window, the count (including that cycle's packet) is copied to the previous-window value and the current count restarts from zero.
- R8: A disabled member is never returned. In flowlet mode, if the entry's link is disabled, the packet goes to the least loaded enabled member by previous-window count.
- R9: When a descriptor reaches selection while `cfgEnable` is all zeros, `outValid` stays low and `noMemberErr` rises. `noMemberErr` stays high until reset.
- R10: While reset is asserted, and right after it, `outValid` and `noMemberErr` are low. The flow table is emptied, and the byte meters, window counter and timestamp counter are cleared.
- R11: `cfgMode` = 3 behaves as static mode.
- R12: Every returned packet writes its table entry with valid set, the chosen link and the timestamp the packet captured at acceptance. A flow that collides on an entry overwrites it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Descriptor valid strobe |
| srcAddr | input | 32 | Source address of the flow |
| dstAddr | input | 32 | Destination address of the flow |
| srcPort | input | 16 | Source port |
| dstPort | input | 16 | Destination port |
| protocol | input | 8 | Protocol number |
| pktLen | input | LEN_W | Packet length in bytes |
| cfgMode | input | 2 | 0 static, 1 flowlet, 2 spray, 3 static |
| cfgEnable | input | NUM_LINKS | Member enable mask |
| cfgThreshold | input | BYTE_W | Previous-window byte threshold for flowlet moves |
| cfgIdleGap | input | TS_W | Idle gap in cycles that separates flowlets |
| outValid | output | 1 | Selection valid |
| outLink | output | IDX_W | Chosen member index |
| noMemberErr | output | 1 | Sticky flag: a packet met an empty enable mask |

## Verification
The static phase uses dozens of distinct flows, each sent repeatedly at large lengths under both a full and a sparse enable mask. This separates the hash-and-rotate choice from any load-driven choice, and table collisions occur along the way. The flowlet phase first runs one flow back to back across several windows, which shows it holds its link while that link is hot. It then brings several flows back after pauses longer than the idle gap, so the threshold comparison and the lowest-index tie rule decide where they move. Masking out links that entries already hold tests the disabled-member rule. The spray phase sends one flow back to back with varied lengths, which tests per-packet spreading by running byte counts. A final phase uses an empty mask and then reset to show the sticky error and its clearing.

// File: rtl/amsel_pkg.sv
package amsel_pkg;

  typedef enum logic [1:0] {
    MODE_STATIC  = 2'd0,
    MODE_FLOWLET = 2'd1,
    MODE_SPRAY   = 2'd2,
    MODE_ALT     = 2'd3
  } selMode_t;

  // Strobes from the decision logic to the datapath for the packet in stage 2.
  typedef struct packed {
    logic commit;
    logic errSet;
    logic tableWrite;
  } ctrlStrobes_t;

  localparam int TUPLE_W = 104;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  // Bit-serial CRC-16, most significant tuple bit first.
  function automatic logic [15:0] tupleCrc(input logic [TUPLE_W-1:0] data);
    logic [15:0] c;
    logic fb;
    c = CRC_SEED;
    for (int i = TUPLE_W - 1; i >= 0; i--) begin
      fb = c[15] ^ data[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/amsel_link_meter.sv
module amsel_link_meter #(
  parameter int BYTE_W = 16,
  parameter int LEN_W  = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addEn,
  input  logic [LEN_W-1:0]  addLen,
  input  logic              winEnd,
  output logic [BYTE_W-1:0] curBytes,
  output logic [BYTE_W-1:0] prevBytes
);

  localparam int PAD_W = BYTE_W + 1 - LEN_W;

  logic [BYTE_W:0]   sumWide;
  logic [BYTE_W-1:0] sumSat;

  always_comb begin
    sumWide = {1'b0, curBytes} + (addEn ? {{PAD_W{1'b0}}, addLen} : '0);
    sumSat  = sumWide[BYTE_W] ? '1 : sumWide[BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curBytes  <= '0;
      prevBytes <= '0;
    end else if (winEnd) begin
      prevBytes <= sumSat;
      curBytes  <= '0;
    end else begin
      curBytes  <= sumSat;
    end
  end

endmodule

// File: rtl/amsel_datapath.sv
module amsel_datapath
  import amsel_pkg::*;
#(
  parameter int NUM_LINKS  = 4,
  parameter int IDX_W      = 2,
  parameter int TBL_DEPTH  = 16,
  parameter int TS_W       = 16,
  parameter int LEN_W      = 14,
  parameter int BYTE_W     = 16,
  parameter int WIN_CYCLES = 64
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              inValid,
  input  logic [TUPLE_W-1:0]                tuple,
  input  logic [LEN_W-1:0]                  pktLen,
  input  ctrlStrobes_t                      strobes,
  input  logic [IDX_W-1:0]                  selLink,
  output logic                              s1Valid,
  output logic [IDX_W-1:0]                  s1Start,
  output logic [TS_W-1:0]                   s1Stamp,
  output logic                              entValid,
  output logic [IDX_W-1:0]                  entLink,
  output logic [TS_W-1:0]                   entStamp,
  output logic [NUM_LINKS-1:0][BYTE_W-1:0]  curBytes,
  output logic [NUM_LINKS-1:0][BYTE_W-1:0]  prevBytes,
  output logic                              outValid,
  output logic [IDX_W-1:0]                  outLink,
  output logic                              noMemberErr
);

  localparam int TBL_W = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1;
  localparam int WIN_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);

  // ---------------- stage 1: hash and capture ----------------
  logic [15:0]      crcVal;
  logic [TBL_W-1:0] s1Idx;
  logic [LEN_W-1:0] s1Len;
  logic [TS_W-1:0]  timer;

  assign crcVal = tupleCrc(tuple);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Idx   <= '0;
      s1Start <= '0;
      s1Len   <= '0;
      s1Stamp <= '0;
      timer   <= '0;
    end else begin
      s1Valid <= inValid;
      s1Idx   <= TBL_W'(crcVal[7:0] % TBL_DEPTH);
      s1Start <= IDX_W'(crcVal[15:8] % NUM_LINKS);
      s1Len   <= pktLen;
      s1Stamp <= timer;
      timer   <= timer + 1'b1;
    end
  end

  // ---------------- measurement window ----------------
  logic [WIN_W-1:0] winCnt;
  logic             winEnd;

  assign winEnd = (winCnt == WIN_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       winCnt <= '0;
    else if (winEnd) winCnt <= '0;
    else             winCnt <= winCnt + 1'b1;
  end

  for (genvar g = 0; g < NUM_LINKS; g++) begin : gMeter
    amsel_link_meter #(
      .BYTE_W(BYTE_W),
      .LEN_W (LEN_W)
    ) u_meter (
      .clk      (clk),
      .rstN     (rstN),
      .addEn    (strobes.commit && (selLink == IDX_W'(g))),
      .addLen   (s1Len),
      .winEnd   (winEnd),
      .curBytes (curBytes[g]),
      .prevBytes(prevBytes[g])
    );
  end

  // ---------------- flow table ----------------
  logic [TBL_DEPTH-1:0] tblValid;
  logic [IDX_W-1:0]     tblLink  [TBL_DEPTH];
  logic [TS_W-1:0]      tblStamp [TBL_DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   tblValid        <= '0;
    else if (strobes.tableWrite) tblValid[s1Idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobes.tableWrite) begin
      tblLink[s1Idx]  <= selLink;
      tblStamp[s1Idx] <= s1Stamp;
    end
  end

  assign entValid = tblValid[s1Idx];
  assign entLink  = tblLink[s1Idx];
  assign entStamp = tblStamp[s1Idx];

  // ---------------- stage 2: result registers ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      outLink     <= '0;
      noMemberErr <= 1'b0;
    end else begin
      outValid <= strobes.commit;
      if (strobes.commit) outLink <= selLink;
      if (strobes.errSet) noMemberErr <= 1'b1;
    end
  end

endmodule

// File: rtl/amsel_control.sv
module amsel_control
  import amsel_pkg::*;
#(
  parameter int NUM_LINKS = 4,
  parameter int IDX_W     = 2,
  parameter int TS_W      = 16,
  parameter int BYTE_W    = 16
) (
  input  selMode_t                          cfgMode,
  input  logic [NUM_LINKS-1:0]              cfgEnable,
  input  logic [BYTE_W-1:0]                 cfgThreshold,
  input  logic [TS_W-1:0]                   cfgIdleGap,
  input  logic                              s1Valid,
  input  logic [IDX_W-1:0]                  s1Start,
  input  logic [TS_W-1:0]                   s1Stamp,
  input  logic                              entValid,
  input  logic [IDX_W-1:0]                  entLink,
  input  logic [TS_W-1:0]                   entStamp,
  input  logic [NUM_LINKS-1:0][BYTE_W-1:0]  curBytes,
  input  logic [NUM_LINKS-1:0][BYTE_W-1:0]  prevBytes,
  output ctrlStrobes_t                      strobes,
  output logic [IDX_W-1:0]                  selLink
);

  // First enabled member at or after the start index, wrapping.
  function automatic logic [IDX_W-1:0] firstFrom(input logic [IDX_W-1:0] start,
                                                 input logic [NUM_LINKS-1:0] en);
    logic [IDX_W-1:0] pick;
    logic found;
    pick  = start;
    found = 1'b0;
    for (int k = 0; k < NUM_LINKS; k++) begin
      if (!found && en[(int'(start) + k) % NUM_LINKS]) begin
        pick  = IDX_W'((int'(start) + k) % NUM_LINKS);
        found = 1'b1;
      end
    end
    return pick;
  endfunction

  // Enabled member with the smallest count; strict compare keeps the lowest index on ties.
  function automatic logic [IDX_W-1:0] leastOf(input logic [NUM_LINKS-1:0][BYTE_W-1:0] cnt,
                                               input logic [NUM_LINKS-1:0] en);
    logic [IDX_W-1:0]  pick;
    logic [BYTE_W-1:0] best;
    logic found;
    pick  = '0;
    best  = '1;
    found = 1'b0;
    for (int i = 0; i < NUM_LINKS; i++) begin
      if (en[i] && (!found || cnt[i] < best)) begin
        pick  = IDX_W'(i);
        best  = cnt[i];
        found = 1'b1;
      end
    end
    return pick;
  endfunction

  logic             anyEnabled;
  logic [IDX_W-1:0] hashLink;
  logic [IDX_W-1:0] lightPrev;
  logic [IDX_W-1:0] lightCur;
  logic [TS_W-1:0]  gap;
  logic             flowletEdge;
  logic             linkHot;

  always_comb begin
    anyEnabled  = |cfgEnable;
    hashLink    = firstFrom(s1Start, cfgEnable);
    lightPrev   = leastOf(prevBytes, cfgEnable);
    lightCur    = leastOf(curBytes, cfgEnable);
    gap         = s1Stamp - entStamp;
    flowletEdge = gap > cfgIdleGap;
    linkHot     = prevBytes[entLink] > cfgThreshold;

    unique case (cfgMode)
      MODE_FLOWLET: begin
        if (!entValid)                 selLink = hashLink;
        else if (!cfgEnable[entLink])  selLink = lightPrev;
        else if (flowletEdge && linkHot) selLink = lightPrev;
        else                           selLink = entLink;
      end
      MODE_SPRAY: selLink = lightCur;
      default:    selLink = hashLink;
    endcase

    strobes.commit     = s1Valid && anyEnabled;
    strobes.errSet     = s1Valid && !anyEnabled;
    strobes.tableWrite = s1Valid && anyEnabled;
  end

endmodule

// File: rtl/multipath_egress_sel.sv
module multipath_egress_sel
  import amsel_pkg::*;
#(
  parameter  int NUM_LINKS  = 4,
  parameter  int TBL_DEPTH  = 16,
  parameter  int TS_W       = 16,
  parameter  int LEN_W      = 14,
  parameter  int BYTE_W     = 16,
  parameter  int WIN_CYCLES = 64,
  localparam int IDX_W      = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [31:0]          srcAddr,
  input  logic [31:0]          dstAddr,
  input  logic [15:0]          srcPort,
  input  logic [15:0]          dstPort,
  input  logic [7:0]           protocol,
  input  logic [LEN_W-1:0]     pktLen,
  input  logic [1:0]           cfgMode,
  input  logic [NUM_LINKS-1:0] cfgEnable,
  input  logic [BYTE_W-1:0]    cfgThreshold,
  input  logic [TS_W-1:0]      cfgIdleGap,
  output logic                 outValid,
  output logic [IDX_W-1:0]     outLink,
  output logic                 noMemberErr
);

  logic [TUPLE_W-1:0]                tuple;
  ctrlStrobes_t                      strobes;
  logic [IDX_W-1:0]                  selLink;
  logic                              s1Valid;
  logic [IDX_W-1:0]                  s1Start;
  logic [TS_W-1:0]                   s1Stamp;
  logic                              entValid;
  logic [IDX_W-1:0]                  entLink;
  logic [TS_W-1:0]                   entStamp;
  logic [NUM_LINKS-1:0][BYTE_W-1:0]  curBytes;
  logic [NUM_LINKS-1:0][BYTE_W-1:0]  prevBytes;

  assign tuple = {srcAddr, dstAddr, srcPort, dstPort, protocol};

  amsel_datapath #(
    .NUM_LINKS (NUM_LINKS),
    .IDX_W     (IDX_W),
    .TBL_DEPTH (TBL_DEPTH),
    .TS_W      (TS_W),
    .LEN_W     (LEN_W),
    .BYTE_W    (BYTE_W),
    .WIN_CYCLES(WIN_CYCLES)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .tuple      (tuple),
    .pktLen     (pktLen),
    .strobes    (strobes),
    .selLink    (selLink),
    .s1Valid    (s1Valid),
    .s1Start    (s1Start),
    .s1Stamp    (s1Stamp),
    .entValid   (entValid),
    .entLink    (entLink),
    .entStamp   (entStamp),
    .curBytes   (curBytes),
    .prevBytes  (prevBytes),
    .outValid   (outValid),
    .outLink    (outLink),
    .noMemberErr(noMemberErr)
  );

  amsel_control #(
    .NUM_LINKS(NUM_LINKS),
    .IDX_W    (IDX_W),
    .TS_W     (TS_W),
    .BYTE_W   (BYTE_W)
  ) u_control (
    .cfgMode     (selMode_t'(cfgMode)),
    .cfgEnable   (cfgEnable),
    .cfgThreshold(cfgThreshold),
    .cfgIdleGap  (cfgIdleGap),
    .s1Valid     (s1Valid),
    .s1Start     (s1Start),
    .s1Stamp     (s1Stamp),
    .entValid    (entValid),
    .entLink     (entLink),
    .entStamp    (entStamp),
    .curBytes    (curBytes),
    .prevBytes   (prevBytes),
    .strobes     (strobes),
    .selLink     (selLink)
  );

endmodule

// File: rtl/amsel_checker.sv
module amsel_checker #(
  parameter int NUM_LINKS = 4,
  parameter int IDX_W     = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic [NUM_LINKS-1:0] cfgEnable,
  input logic                 outValid,
  input logic [IDX_W-1:0]     outLink,
  input logic                 noMemberErr
);

  // Enable mask seen at the edge that produced the current output.
  logic [NUM_LINKS-1:0] enSeen;
  always_ff @(posedge clk) enSeen <= cfgEnable;

  // R1: a result only appears two cycles after an accepted descriptor
  a_r1_two_cycle_result: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 2));

  // R8: the returned member was enabled when it was chosen
  a_r8_enabled_member: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> enSeen[outLink]);

  // R9: an empty mask blocks any result
  a_r9_quiet_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable == '0) |=> !outValid);

  // R9: a descriptor meeting an empty mask raises the flag
  a_r9_flag_raised: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid) && (cfgEnable == '0)) |=> noMemberErr);

  // R9: the flag holds until reset
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    noMemberErr |=> noMemberErr);

endmodule

bind multipath_egress_sel amsel_checker #(
  .NUM_LINKS(NUM_LINKS),
  .IDX_W    (IDX_W)
) u_check (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .cfgEnable  (cfgEnable),
  .outValid   (outValid),
  .outLink    (outLink),
  .noMemberErr(noMemberErr)
);

// File: tb/multipath_egress_sel_tb.sv
module multipath_egress_sel_tb;

  localparam int NL  = 4;
  localparam int TD  = 16;
  localparam int WIN = 64;
  localparam int HALF = 10; // 20 ns period, 50 MHz

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] srcAddr = '0;
  logic [31:0] dstAddr = '0;
  logic [15:0] srcPort = '0;
  logic [15:0] dstPort = '0;
  logic [7:0]  protocol = '0;
  logic [13:0] pktLen = '0;
  logic [1:0]  cfgMode = 2'd0;
  logic [3:0]  cfgEnable = 4'hF;
  logic [15:0] cfgThreshold = 16'd2000;
  logic [15:0] cfgIdleGap = 16'd6;
  logic        outValid;
  logic [1:0]  outLink;
  logic        noMemberErr;

  int  vectors = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always #HALF clk = ~clk;

  multipath_egress_sel #(
    .NUM_LINKS(NL), .TBL_DEPTH(TD), .TS_W(16), .LEN_W(14), .BYTE_W(16), .WIN_CYCLES(WIN)
  ) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .srcPort(srcPort), .dstPort(dstPort),
    .protocol(protocol), .pktLen(pktLen), .cfgMode(cfgMode), .cfgEnable(cfgEnable),
    .cfgThreshold(cfgThreshold), .cfgIdleGap(cfgIdleGap),
    .outValid(outValid), .outLink(outLink), .noMemberErr(noMemberErr)
  );

  // ---------------- reference computations from the requirements ----------------
  function automatic logic [15:0] refCrc(input logic [103:0] d);
    logic [15:0] r;
    r = 16'hFFFF;
    for (int b = 103; b >= 0; b--) begin
      if (r[15] ^ d[b]) r = (r << 1) ^ 16'h1021;
      else              r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [1:0] refHashed(input int st, input logic [3:0] en);
    for (int k = 0; k < NL; k++) begin
      if (en[(st + k) % NL]) return 2'((st + k) % NL);
    end
    return 2'(st);
  endfunction

  function automatic logic [1:0] refLightest(input logic [15:0] c [NL], input logic [3:0] en);
    int bestI;
    bestI = -1;
    for (int i = 0; i < NL; i++) begin
      if (en[i]) begin
        if (bestI < 0) bestI = i;
        else if (c[i] < c[bestI]) bestI = i;
      end
    end
    return (bestI < 0) ? 2'd0 : 2'(bestI);
  endfunction

  // ---------------- cycle model ----------------
  logic [15:0] mCur  [NL];
  logic [15:0] mPrev [NL];
  logic        mTv   [TD];
  logic [1:0]  mTl   [TD];
  logic [15:0] mTs   [TD];
  logic [15:0] mTimer;
  int          mWin;
  logic        m1Valid;
  logic [15:0] m1Crc;
  logic [13:0] m1Len;
  logic [15:0] m1Stamp;
  logic        expValid = 1'b0;
  logic [1:0]  expLink = 2'd0;
  logic        expErr = 1'b0;
  string       expTag = "R10";

  always @(posedge clk) begin
    logic       anyEn;
    logic       commit;
    logic [1:0] pick;
    int         ti;
    int         st;
    logic [15:0] gap;
    logic [16:0] s;
    string      tag;
    if (!rstN) begin
      for (int i = 0; i < NL; i++) begin mCur[i] = '0; mPrev[i] = '0; end
      for (int i = 0; i < TD; i++) mTv[i] = 1'b0;
      mTimer = '0; mWin = 0; m1Valid = 1'b0; m1Crc = '0; m1Len = '0; m1Stamp = '0;
      expValid = 1'b0; expErr = 1'b0; expTag = "R10";
    end else begin
      anyEn  = |cfgEnable;
      commit = m1Valid && anyEn;
      pick   = 2'd0;
      tag    = "R1";
      ti     = int'(m1Crc[7:0]) % TD;
      st     = int'(m1Crc[15:8]) % NL;
      if (m1Valid && !anyEn) begin
        expErr = 1'b1;
        tag = "R9";
      end else if (commit) begin
        case (cfgMode)
          2'd1: begin
            gap = m1Stamp - mTs[ti];
            if (!mTv[ti]) begin
              pick = refHashed(st, cfgEnable); tag = "R3";
            end else if (!cfgEnable[mTl[ti]]) begin
              pick = refLightest(mPrev, cfgEnable); tag = "R8";
            end else if (gap > cfgIdleGap) begin
              tag = "R5 R7";
              if (mPrev[mTl[ti]] > cfgThreshold) pick = refLightest(mPrev, cfgEnable);
              else pick = mTl[ti];
            end else begin
              pick = mTl[ti]; tag = "R4";
            end
          end
          2'd2: begin pick = refLightest(mCur, cfgEnable); tag = "R6 R7"; end
          2'd3: begin pick = refHashed(st, cfgEnable); tag = "R11"; end
          default: begin pick = refHashed(st, cfgEnable); tag = "R2"; end
        endcase
      end
      expValid = commit;
      if (commit) expLink = pick;
      expTag = tag;
      // R7: byte meters and window
      for (int i = 0; i < NL; i++) begin
        s = {1'b0, mCur[i]} + ((commit && pick == 2'(i)) ? {3'b0, m1Len} : 17'd0);
        if (s > 17'h0FFFF) s = 17'h0FFFF;
        if (mWin == WIN - 1) begin mPrev[i] = s[15:0]; mCur[i] = '0; end
        else mCur[i] = s[15:0];
      end
      mWin = (mWin == WIN - 1) ? 0 : mWin + 1;
      // R12: table update
      if (commit) begin mTv[ti] = 1'b1; mTl[ti] = pick; mTs[ti] = m1Stamp; end
      // stage 1 capture
      m1Valid = inValid;
      m1Crc   = refCrc({srcAddr, dstAddr, srcPort, dstPort, protocol});
      m1Len   = pktLen;
      m1Stamp = mTimer;
      mTimer  = mTimer + 16'd1;
    end
  end

  // ---------------- comparison, away from the edge ----------------
  always @(posedge clk) begin
    #5;
    if (!done) begin
      vectors++;
      if (noMemberErr !== expErr) begin
        fails++;
        $display("FAIL R9: noMemberErr=%0d expected %0d at %0t", noMemberErr, expErr, $time);
      end else if (outValid !== expValid || (expValid && outLink !== expLink)) begin
        fails++;
        $display("FAIL %s: outValid=%0d outLink=%0d expected outValid=%0d outLink=%0d at %0t",
                 expTag, outValid, outLink, expValid, expLink, $time);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic sendPkt(input int flow, input int len);
    @(negedge clk);
    inValid  = 1'b1;
    srcAddr  = 32'h0A00_0000 + 32'(flow * 7);
    dstAddr  = 32'hC0A8_0000 ^ 32'(flow * 131);
    srcPort  = 16'(1000 + flow);
    dstPort  = 16'd4791;
    protocol = 8'd17;
    pktLen   = 14'(len);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  initial begin
    // R10: reset state
    idle(4);
    rstN = 1'b1;
    idle(3);

    // R2: static hashing, full mask, then repeated at heavy length
    cfgMode = 2'd0; cfgEnable = 4'b1111;
    for (int f = 0; f < 48; f++) sendPkt(f, 64 + f);
    for (int f = 0; f < 48; f++) sendPkt(f, 1500);
    idle(4);
    // R2 R8: sparse mask rotates to enabled members
    cfgEnable = 4'b0110;
    for (int f = 0; f < 32; f++) sendPkt(f, 200);
    idle(4);

    // R3 R4: flowlet mode, one flow back to back across windows stays put
    cfgMode = 2'd1; cfgEnable = 4'b1111; cfgThreshold = 16'd2000; cfgIdleGap = 16'd6;
    for (int p = 0; p < 200; p++) sendPkt(100, 300);
    // R5 R7: flows return after gaps beyond the idle gap
    for (int r = 0; r < 30; r++) begin
      idle(10);
      for (int f = 100; f < 104; f++) begin
        sendPkt(f, 400 + r * 13);
        sendPkt(f, 400);
      end
    end
    // R5: gap exactly at the idle gap keeps the link
    for (int r = 0; r < 6; r++) begin
      sendPkt(100, 900);
      idle(5);
    end
    // R8: links held by entries get disabled
    cfgEnable = 4'b1010;
    for (int f = 100; f < 108; f++) sendPkt(f, 500);
    idle(12);
    cfgEnable = 4'b0101;
    for (int f = 100; f < 108; f++) sendPkt(f, 500);
    idle(4);

    // R6 R7: spraying one flow back to back
    cfgMode = 2'd2; cfgEnable = 4'b1111;
    for (int p = 0; p < 100; p++) sendPkt(7, 64 + (p * 37) % 1400);
    cfgEnable = 4'b1101;
    for (int p = 0; p < 40; p++) sendPkt(7, 1500 - p * 20);
    idle(4);

    // R11: mode 3 acts as static
    cfgMode = 2'd3; cfgEnable = 4'b1111;
    for (int f = 0; f < 16; f++) sendPkt(f, 300);
    idle(4);

    // R9: empty mask, then restore; flag stays up
    cfgMode = 2'd1; cfgEnable = 4'b0000;
    for (int p = 0; p < 5; p++) sendPkt(p, 100);
    idle(3);
    cfgEnable = 4'b1111;
    for (int p = 0; p < 5; p++) sendPkt(p, 100);
    idle(4);

    // R10: reset clears the flag and state
    rstN = 1'b0;
    idle(3);
    rstN = 1'b1;
    idle(3);
    for (int f = 0; f < 8; f++) sendPkt(f, 100);
    idle(5);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(2 * HALF * 200000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R1: watchdog expired, finished=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule